// File: doc/BRIEF.md
# Memory Bitfield Read-Modify-Write Sequencer

This block carries out bitfield operations on a field held in byte-addressed, big-endian memory. The caller supplies a base byte address, a bit offset counted from the most significant bit of that byte, a field width of 1 to 32 bits, an operation code and a 32-bit auxiliary operand. The block turns the offset into a byte displacement and a residual bit position of 0 to 7. It then fetches only the bytes the field covers, between one and five, into a 64-bit window.

From the window it derives the negative and zero flags and, depending on the operation, an extracted value or the position of the first set bit. For the four modifying operations it edits the window and writes the same bytes back to the same addresses, lowest address first. Memory is reached one byte per transfer over a request/ready bus. A start strobe begins an operation and a one-cycle done pulse ends it.

Top module: `bitfield_rmw_seq`

## Requirements
- R1: For an accepted start, the block reads exactly n = (r + w + 7) / 8 bytes, one per handshake, at addresses A, A+1, ... A+n-1. Here A = base_addr + (bit_ofs >> 3), r = bit_ofs mod 8 and w = fld_width.
- R2: A request stays asserted with unchanged address, direction and write data until mem_ready is sampled high; stalls do not change the bytes transferred.
- R3: At done, flag_n equals the most significant bit of the field and flag_z is 1 exactly when all w field bits are 0, for every op_sel value. Field bit j (0 = most significant) is memory bit 7-((r+j) mod 8) of byte A+(r+j)/8.
- R4: op_sel 1 (extract unsigned) returns the field zero-extended to 32 bits on result.
- R5: op_sel 3 (extract signed) returns the field sign-extended from its most significant bit on result.
- R6: op_sel 5 (find first one) returns bit_ofs + j on result, where j is the index of the first set field bit from the most significant end, or bit_ofs + w if none is set.
- R7: op_sel 2 (toggle), 4 (clear) and 6 (set) invert, zero or set every field bit. They then write the n bytes back to A..A+n-1 in ascending order and leave all other bits unchanged.
- R8: op_sel 7 (insert) replaces field bit j with bit w-1-j of aux_val, writes back like R7 and leaves all other bits unchanged.
- R9: op_sel 0 (test), 1, 3 and 5 issue no memory writes.
- R10: done is a single-cycle pulse after the last transfer, with no request active in that cycle. A start raised while an operation is in progress is ignored.
- R11: For op_sel 0, 2, 4, 6 and 7, result is 0 at done.
- R12: After reset, mem_req, done, result, flag_n and flag_z are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_sel | input | 3 | Operation code |
| base_addr | input | AW | Base byte address |
| bit_ofs | input | OW | Bit offset from the MSB of the base byte |
| fld_width | input | 6 | Field width, 1 to 32 |
| aux_val | input | 32 | Source bits for insert |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Extracted value or find-first-one position |
| flag_n | output | 1 | Field most significant bit |
| flag_z | output | 1 | Field is all zeros |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | AW | Byte address of the transfer |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes at this edge |

## Verification
The checker assumes fld_width stays between 1 and 32 and that the memory side answers every request eventually. It also assumes op_sel is sampled only with an accepted start, so it tracks the read-only class from the start strobe itself. The directed stimulus uses only legal widths. Its memory responder always grants within three cycles, including a stalling mode that withholds mem_ready in a fixed pattern. Bases are kept small enough that every touched byte lies inside the modelled 256-byte space.

// File: rtl/bitfield_rmw_seq.sv
module bitfield_rmw_seq #(
  parameter int AW = 32,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_sel,
  input  logic [AW-1:0] base_addr,
  input  logic [OW-1:0] bit_ofs,
  input  logic [5:0]    fld_width,
  input  logic [31:0]   aux_val,
  output logic          done,
  output logic [31:0]   result,
  output logic          flag_n,
  output logic          flag_z,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CALC, S_WRITE, S_DONE} st_t;

  st_t           st;
  logic [2:0]    op_q, bofs_q, nbytes_q, idx;
  logic [OW-1:0] ofs_q;
  logic [5:0]    wid_q;
  logic [31:0]   aux_q;
  logic [AW-1:0] addr_q;
  logic [63:0]   win;

  logic [6:0]  span_in, pos;
  logic [5:0]  sh32, lead, byte_sh;
  logic [31:0] hi, fl_left, extu, exts, ffo_res;
  logic [63:0] lowmask, m64, ins64, new_win;
  logic        wr_op, last;

  assign span_in = 7'(bit_ofs[2:0]) + 7'(fld_width) + 7'd7;
  assign byte_sh = 6'd56 - {idx, 3'b000};
  assign last    = (idx == nbytes_q - 3'd1);
  assign wr_op   = (op_q == 3'd2) || (op_q == 3'd4) || (op_q == 3'd6) || (op_q == 3'd7);

  assign sh32    = 6'd32 - wid_q;
  assign hi      = 32'(win >> (6'd32 - 6'(bofs_q)));
  assign fl_left = hi & (32'hFFFF_FFFF << sh32);
  assign extu    = fl_left >> sh32;
  assign exts    = $unsigned($signed(fl_left) >>> sh32);

  always_comb begin
    lead = wid_q;
    for (int i = 0; i < 32; i++)
      if (fl_left[i]) lead = 6'(31 - i);
  end
  assign ffo_res = 32'(ofs_q) + 32'(lead);

  assign lowmask = (64'd1 << wid_q) - 64'd1;
  assign pos     = 7'd64 - 7'(bofs_q) - 7'(wid_q);
  assign m64     = lowmask << pos;
  assign ins64   = (64'(aux_q) & lowmask) << pos;

  always_comb begin
    case (op_q)
      3'd2:    new_win = win ^ m64;
      3'd4:    new_win = win & ~m64;
      3'd6:    new_win = win | m64;
      3'd7:    new_win = (win & ~m64) | ins64;
      default: new_win = win;
    endcase
  end

  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = addr_q + AW'(idx);
  assign mem_wdata = 8'(win >> byte_sh);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      bofs_q   <= '0;
      nbytes_q <= '0;
      idx      <= '0;
      ofs_q    <= '0;
      wid_q    <= '0;
      aux_q    <= '0;
      addr_q   <= '0;
      win      <= '0;
      result   <= '0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q     <= op_sel;
          ofs_q    <= bit_ofs;
          bofs_q   <= bit_ofs[2:0];
          wid_q    <= fld_width;
          aux_q    <= aux_val;
          addr_q   <= base_addr + AW'(bit_ofs >> 3);
          nbytes_q <= span_in[5:3];
          idx      <= '0;
          win      <= '0;
          st       <= S_READ;
        end
        S_READ: if (mem_ready) begin
          win <= win | (64'(mem_rdata) << byte_sh);
          if (last) st <= S_CALC;
          else      idx <= idx + 3'd1;
        end
        S_CALC: begin
          flag_n <= fl_left[31];
          flag_z <= (fl_left == '0);
          case (op_q)
            3'd1:    result <= extu;
            3'd3:    result <= exts;
            3'd5:    result <= ffo_res;
            default: result <= '0;
          endcase
          if (wr_op) begin
            win <= new_win;
            idx <= '0;
            st  <= S_WRITE;
          end else begin
            st <= S_DONE;
          end
        end
        S_WRITE: if (mem_ready) begin
          if (last) st <= S_DONE;
          else      idx <= idx + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitfield_rmw_seq_chk.sv
module bitfield_rmw_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    op_sel,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata
);

  logic       busy_c, ro_c;
  logic [3:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      ro_c   <= 1'b0;
      rd_cnt <= '0;
    end else if (!busy_c && start) begin
      busy_c <= 1'b1;
      ro_c   <= (op_sel == 3'd0) || (op_sel == 3'd1) || (op_sel == 3'd3) || (op_sel == 3'd5);
      rd_cnt <= '0;
    end else if (done) begin
      busy_c <= 1'b0;
    end else if (mem_req && mem_ready && !mem_we) begin
      rd_cnt <= rd_cnt + 4'd1;
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_c |-> !mem_req && !done);

  a_r9_ro_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy_c && ro_c |-> !(mem_req && mem_we));

  a_r1_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 4'd5);

endmodule

bind bitfield_rmw_seq bitfield_rmw_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/bitfield_rmw_seq_bench.sv
`timescale 1ns/1ps
module bitfield_rmw_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] base_addr = '0, bit_ofs = '0, aux_val = '0;
  logic [5:0]  fld_width = 6'd1;
  logic        done, flag_n, flag_z, mem_req, mem_we;
  logic [31:0] result, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 1'b0;

  bitfield_rmw_seq u_bitfield_rmw_seq (.*);

  always #4 clk = ~clk;

  logic [7:0]  mem [0:255];
  logic [7:0]  ref_mem [0:255];
  logic [31:0] rlog [0:7];
  logic [31:0] wlog [0:7];
  int rd_n, wr_n, n_chk, n_bad, stall_cnt;
  bit stall_on;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    logic p_req, p_rdy, p_we, rdy;
    logic [31:0] p_addr;
    logic [7:0] p_wd;
    p_req = 0; p_rdy = 0; p_we = 0; p_addr = 0; p_wd = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    forever begin
      @(negedge clk);
      if (p_req && p_rdy) begin
        if (p_we) begin
          mem[p_addr[7:0]] = p_wd;
          if (wr_n < 8) wlog[wr_n] = p_addr;
          wr_n++;
        end else begin
          if (rd_n < 8) rlog[rd_n] = p_addr;
          rd_n++;
        end
      end
      stall_cnt++;
      rdy = stall_on ? (stall_cnt % 3 != 2) : 1'b1;
      mem_ready = rdy;
      mem_rdata = mem[mem_addr[7:0]];
      p_req = mem_req; p_rdy = rdy; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
    end
  end

  task automatic run_op(input logic [2:0] o, input logic [31:0] base, input logic [31:0] ofs,
                        input int w, input logic [31:0] aux, input bit poke);
    logic [31:0] ea, fld, exp_res;
    logic [63:0] sx;
    int b, n, first, guard;
    bit wop, rd_ok, wr_ok, mem_ok;
    string rtag, mtag, wtag;
    ea = base + (ofs >> 3);
    b = int'(ofs & 32'd7);
    n = (b + w + 7) / 8;
    wop = (o == 3'd2) || (o == 3'd4) || (o == 3'd6) || (o == 3'd7);
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    fld = 0; first = w;
    for (int j = 0; j < w; j++) begin
      logic [31:0] a;
      int k;
      logic bt;
      a = ea + 32'((b + j) / 8);
      k = 7 - ((b + j) % 8);
      bt = mem[a[7:0]][k];
      fld = {fld[30:0], bt};
      if (bt && first == w) first = j;
      case (o)
        3'd2: ref_mem[a[7:0]][k] = ~bt;
        3'd4: ref_mem[a[7:0]][k] = 1'b0;
        3'd6: ref_mem[a[7:0]][k] = 1'b1;
        3'd7: ref_mem[a[7:0]][k] = aux[w - 1 - j];
        default: ;
      endcase
    end
    sx = {32'b0, fld};
    if (fld[w-1]) sx = sx | (~64'd0 << w);
    case (o)
      3'd1:    begin exp_res = fld;                 rtag = "R4";  end
      3'd3:    begin exp_res = sx[31:0];            rtag = "R5";  end
      3'd5:    begin exp_res = ofs + 32'(first);    rtag = "R6";  end
      default: begin exp_res = 0;                   rtag = "R11"; end
    endcase
    mtag = (o == 3'd7) ? "R8" : "R7";
    wtag = wop ? "R7" : "R9";
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    op_sel = o; base_addr = base; bit_ofs = ofs; fld_width = 6'(w); aux_val = aux; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      op_sel = ~o; aux_val = ~aux; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(done === 1'b1, "R10", "done seen", 64'(done), 64'd1);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
    chk(result === exp_res, rtag, "result", 64'(result), 64'(exp_res));
    chk({flag_n, flag_z} === {fld[w-1], fld == 0}, "R3", "flags N,Z",
        64'({flag_n, flag_z}), 64'({fld[w-1], fld == 0}));
    rd_ok = (rd_n == n);
    for (int k = 0; k < n && k < 8; k++) if (rlog[k] !== ea + 32'(k)) rd_ok = 0;
    chk(rd_ok, stall_on ? "R2" : "R1", "read count/addresses", 64'(rd_n), 64'(n));
    wr_ok = (wr_n == (wop ? n : 0));
    for (int k = 0; k < wr_n && k < 8; k++) if (wlog[k] !== ea + 32'(k)) wr_ok = 0;
    chk(wr_ok, wtag, "write count/addresses", 64'(wr_n), 64'(wop ? n : 0));
    mem_ok = 1;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mem_ok = 0;
    chk(mem_ok, mtag, "memory image", 64'(mem[ea[7:0]]), 64'(ref_mem[ea[7:0]]));
  endtask

  task automatic t_reset;
    chk(mem_req === 1'b0 && done === 1'b0, "R12", "req/done after reset",
        64'({mem_req, done}), 64'd0);
    chk(result === 32'd0 && flag_n === 1'b0 && flag_z === 1'b0, "R12", "result/flags after reset",
        64'({result, flag_n, flag_z}), 64'd0);
  endtask

  task automatic t_extract;
    run_op(3'd1, 32'd16, 32'd0, 8, 0, 0);
    run_op(3'd1, 32'd16, 32'd39, 32, 0, 0);
    run_op(3'd3, 32'd20, 32'd13, 5, 0, 0);
    run_op(3'd3, 32'd20, 32'd3, 32, 0, 0);
    run_op(3'd1, 32'd40, 32'd6, 1, 0, 0);
  endtask

  task automatic t_test_ffo;
    run_op(3'd0, 32'd50, 32'd10, 12, 0, 0);
    run_op(3'd4, 32'd60, 32'd4, 16, 0, 0);
    run_op(3'd0, 32'd60, 32'd4, 16, 0, 0);
    run_op(3'd5, 32'd60, 32'd4, 16, 0, 0);
    run_op(3'd5, 32'd70, 32'd21, 20, 0, 0);
  endtask

  task automatic t_modify_stall;
    stall_on = 1;
    run_op(3'd2, 32'd80, 32'd7, 32, 0, 0);
    run_op(3'd6, 32'd90, 32'd2, 3, 0, 0);
    run_op(3'd4, 32'd100, 32'd12, 9, 0, 0);
    run_op(3'd3, 32'd104, 32'd1, 20, 0, 0);
    stall_on = 0;
  endtask

  task automatic t_insert;
    run_op(3'd7, 32'd110, 32'd5, 32, 32'hA5C3_1E77, 0);
    run_op(3'd7, 32'd120, 32'd1, 3, 32'hFFFF_FFF5, 0);
    run_op(3'd7, 32'd130, 32'd0, 32, 32'h8000_0001, 0);
  endtask

  task automatic t_busy_start;
    run_op(3'd1, 32'd140, 32'd9, 24, 0, 1);
    run_op(3'd6, 32'd150, 32'd14, 11, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_extract();
    t_test_ffo();
    t_modify_stall();
    t_insert();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule